// File: doc/BRIEF.md
# External Bus Byte-Lane Sequencer

This block sits between an internal bus master and a 16-bit external data bus. It takes one byte, word or longword request and runs it as one or more external bus cycles. The number of cycles depends on whether the addressed area is 8 or 16 bits wide. For a write it places each piece of the data on the correct byte lane. For a read it gathers the returned bytes or words into a 32-bit result.

The master offers a request with `req_valid`. The request is taken on any clock edge where `busy` is low. The area width comes from an external decoder on `area_8bit`. Each external cycle is held until the bus side returns `ext_ack`. After the last cycle is acknowledged, the block pulses `done` for one cycle and drops `busy`. For a read, `rd_data` holds the result during that cycle.

Top module: `xbus_align_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done`, `ext_cyc`, `ext_lane_hi` and `ext_lane_lo` are all low.
- R2: In an 8-bit area (`area_8bit`=1) every external cycle asserts `ext_lane_hi` only. `ext_wdata[7:0]` stays zero.
- R3: Size is coded 0 = byte, 1 = word, 2 = longword, and code 3 is treated as a longword. An 8-bit area takes 1, 2 or 4 external cycles for these sizes. A 16-bit area takes 1, 1 or 2.
- R4: Write data goes out most-significant part first. In an 8-bit area the bytes are sent as bits 31..24, 23..16, 15..8, 7..0, using only as many as the size needs, on `ext_wdata[15:8]`. In a 16-bit area a longword sends bits 31..16 and then 15..0. A word sends bits 15..0, and a byte sends bits 7..0 on its lane. Reads put 0 on `ext_wdata`.
- R5: The first external address equals `req_addr`, except that bit 0 is cleared for a word or longword in a 16-bit area. Between cycles the address goes up by 1 in an 8-bit area and by 2 in a 16-bit area, wrapping at the address width.
- R6: In a 16-bit area a byte access uses the upper lane when address bit 0 is 0 and the lower lane when it is 1. Word and longword cycles assert both lanes.
- R7: For a read, `rd_data` during the `done` cycle holds the gathered value, zero-extended to 32 bits. Bytes come from `ext_rdata[15:8]` in an 8-bit area and from the selected lane for a 16-bit byte access. Earlier parts land in the more significant positions.
- R8: `busy` is high from the cycle after a request is taken until the last external cycle is acknowledged. Requests offered while `busy` is high are ignored.
- R9: `ext_cyc` equals `busy`. Address, data, lanes and `ext_we` hold steady while `ext_ack` is low.
- R10: The cycle after the last acknowledge, `done` is high for exactly one cycle and `busy`, `ext_cyc` and both lane enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, right-aligned |
| area_8bit | input | 1 | 1 = addressed area is 8 bits wide |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Gathered read result, valid with done |
| ext_cyc | output | 1 | External cycle active |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | ADDR_W | External byte address |
| ext_wdata | output | 16 | External write data, both lanes |
| ext_lane_hi | output | 1 | Upper lane (15..8) valid |
| ext_lane_lo | output | 1 | Lower lane (7..0) valid |
| ext_rdata | input | 16 | External read data |
| ext_ack | input | 1 | Current external cycle completes |

## Verification
The assertions assume that `ext_ack` is raised only while `ext_cyc` is high, and that `area_8bit` and the request fields are valid whenever `req_valid` is high. The stimulus follows the first rule: it drives `ext_ack` only in cycles where the model holds a transfer in flight, and it delays the acknowledge by a random number of cycles. It still offers random requests while busy, to exercise the ignore rule. It also drives random `ext_rdata` in every cycle, so that sampling the wrong lane or the wrong cycle shows up.

// File: rtl/xbus_align_pkg.sv
package xbus_align_pkg;

    localparam int LANE_W  = 8;
    localparam int EXT_W   = 2 * LANE_W;
    localparam int INT_W   = 4 * LANE_W;
    localparam int STEP_W  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    function automatic size_e norm_size(input logic [1:0] raw);
        size_e s;
        case (raw)
            2'd0:    s = SZ_BYTE;
            2'd1:    s = SZ_WORD;
            default: s = SZ_LONG;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xbus_step_plan.sv
module xbus_step_plan
    import xbus_align_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  size_e                     size_i,
    input  logic                      is8_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output logic [STEP_W-1:0]         last_step_o,
    output logic [ADDR_W-1:0]         start_addr_o
);

    always_comb begin
        last_step_o = '0;
        if (is8_i) begin
            case (size_i)
                SZ_BYTE: last_step_o = STEP_W'(0);
                SZ_WORD: last_step_o = STEP_W'(1);
                default: last_step_o = STEP_W'(3);
            endcase
        end else begin
            case (size_i)
                SZ_BYTE: last_step_o = STEP_W'(0);
                SZ_WORD: last_step_o = STEP_W'(0);
                default: last_step_o = STEP_W'(1);
            endcase
        end
    end

    always_comb begin
        start_addr_o = addr_i;
        if (!is8_i && size_i != SZ_BYTE) begin
            start_addr_o[0] = 1'b0;
        end
    end

endmodule

// File: rtl/xbus_lane_steer.sv
module xbus_lane_steer
    import xbus_align_pkg::*;
(
    input  logic                 active_i,
    input  logic                 write_i,
    input  logic                 is8_i,
    input  size_e                size_i,
    input  logic                 odd_i,
    input  logic [STEP_W-1:0]    step_i,
    input  logic [STEP_W-1:0]    last_step_i,
    input  logic [INT_W-1:0]     wdata_i,
    output logic                 lane_hi_o,
    output logic                 lane_lo_o,
    output logic [EXT_W-1:0]     wdata_o
);

    logic [STEP_W-1:0] part_idx;
    logic [INT_W-1:0]  byte_shift;
    logic [INT_W-1:0]  word_shift;
    logic [LANE_W-1:0] sel_byte;
    logic [EXT_W-1:0]  sel_word;

    // Parts count down from the most significant one.
    assign part_idx   = last_step_i - step_i;
    assign byte_shift = wdata_i >> {part_idx, 3'b000};
    assign word_shift = wdata_i >> {part_idx, 4'b0000};
    assign sel_byte   = byte_shift[LANE_W-1:0];
    assign sel_word   = word_shift[EXT_W-1:0];

    always_comb begin
        lane_hi_o = 1'b0;
        lane_lo_o = 1'b0;
        if (active_i) begin
            if (is8_i) begin
                lane_hi_o = 1'b1;
            end else if (size_i == SZ_BYTE) begin
                lane_hi_o = !odd_i;
                lane_lo_o = odd_i;
            end else begin
                lane_hi_o = 1'b1;
                lane_lo_o = 1'b1;
            end
        end
    end

    always_comb begin
        wdata_o = '0;
        if (active_i && write_i) begin
            if (is8_i) begin
                wdata_o = {sel_byte, {LANE_W{1'b0}}};
            end else if (size_i == SZ_BYTE) begin
                wdata_o = odd_i ? {{LANE_W{1'b0}}, wdata_i[LANE_W-1:0]}
                                : {wdata_i[LANE_W-1:0], {LANE_W{1'b0}}};
            end else begin
                wdata_o = sel_word;
            end
        end
    end

endmodule

// File: rtl/xbus_rd_gather.sv
module xbus_rd_gather
    import xbus_align_pkg::*;
(
    input  logic                 is8_i,
    input  size_e                size_i,
    input  logic                 odd_i,
    input  logic [INT_W-1:0]     acc_i,
    input  logic [EXT_W-1:0]     rdata_i,
    output logic [INT_W-1:0]     acc_o
);

    logic [LANE_W-1:0] byte_in;

    always_comb begin
        if (!is8_i && size_i == SZ_BYTE && odd_i) begin
            byte_in = rdata_i[LANE_W-1:0];
        end else begin
            byte_in = rdata_i[EXT_W-1:LANE_W];
        end
    end

    always_comb begin
        if (is8_i || size_i == SZ_BYTE) begin
            acc_o = {acc_i[INT_W-LANE_W-1:0], byte_in};
        end else begin
            acc_o = {acc_i[INT_W-EXT_W-1:0], rdata_i};
        end
    end

endmodule

// File: rtl/xbus_align_seq.sv
module xbus_align_seq
    import xbus_align_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [INT_W-1:0]     req_wdata,
    input  logic                 area_8bit,
    output logic                 busy,
    output logic                 done,
    output logic [INT_W-1:0]     rd_data,
    output logic                 ext_cyc,
    output logic                 ext_we,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic [EXT_W-1:0]     ext_wdata,
    output logic                 ext_lane_hi,
    output logic                 ext_lane_lo,
    input  logic [EXT_W-1:0]     ext_rdata,
    input  logic                 ext_ack
);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               wr;
        logic               is8;
        size_e              size;
        logic               odd;
        logic [ADDR_W-1:0]  addr;
        logic [STEP_W-1:0]  step;
        logic [STEP_W-1:0]  last;
        logic [INT_W-1:0]   wdata;
        logic [INT_W-1:0]   acc;
    } seq_state_t;

    seq_state_t state_d, state_q;

    size_e              req_size_n;
    logic [STEP_W-1:0]  plan_last;
    logic [ADDR_W-1:0]  plan_start;
    logic [INT_W-1:0]   acc_next;
    logic               final_step;

    assign req_size_n = norm_size(req_size);
    assign final_step = (state_q.step == state_q.last);

    xbus_step_plan #(.ADDR_W(ADDR_W)) plan_i (
        .size_i       (req_size_n),
        .is8_i        (area_8bit),
        .addr_i       (req_addr),
        .last_step_o  (plan_last),
        .start_addr_o (plan_start)
    );

    xbus_lane_steer steer_i (
        .active_i    (state_q.busy),
        .write_i     (state_q.wr),
        .is8_i       (state_q.is8),
        .size_i      (state_q.size),
        .odd_i       (state_q.odd),
        .step_i      (state_q.step),
        .last_step_i (state_q.last),
        .wdata_i     (state_q.wdata),
        .lane_hi_o   (ext_lane_hi),
        .lane_lo_o   (ext_lane_lo),
        .wdata_o     (ext_wdata)
    );

    xbus_rd_gather gather_i (
        .is8_i   (state_q.is8),
        .size_i  (state_q.size),
        .odd_i   (state_q.odd),
        .acc_i   (state_q.acc),
        .rdata_i (ext_rdata),
        .acc_o   (acc_next)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (req_valid) begin
                state_d.busy  = 1'b1;
                state_d.wr    = req_write;
                state_d.is8   = area_8bit;
                state_d.size  = req_size_n;
                state_d.odd   = req_addr[0];
                state_d.addr  = plan_start;
                state_d.step  = '0;
                state_d.last  = plan_last;
                state_d.wdata = req_write ? req_wdata : '0;
                state_d.acc   = '0;
            end
        end else if (ext_ack) begin
            if (!state_q.wr) begin
                state_d.acc = acc_next;
            end
            if (final_step) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.step = state_q.step + STEP_W'(1);
                state_d.addr = state_q.addr + (state_q.is8 ? ADDR_W'(1) : ADDR_W'(2));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.size <= SZ_BYTE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy     = state_q.busy;
    assign done     = state_q.done;
    assign rd_data  = state_q.acc;
    assign ext_cyc  = state_q.busy;
    assign ext_we   = state_q.busy && state_q.wr;
    assign ext_addr = state_q.addr;

    // R2: an 8-bit area only ever uses the upper lane
    a_r2_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && state_q.is8) |-> (ext_lane_hi && !ext_lane_lo && ext_wdata[LANE_W-1:0] == '0));

    // R6: a byte in a 16-bit area uses exactly one lane, wider sizes use both
    a_r6_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !state_q.is8 && state_q.size == SZ_BYTE) |-> $onehot({ext_lane_hi, ext_lane_lo}));
    a_r6_wide_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !state_q.is8 && state_q.size != SZ_BYTE) |-> (ext_lane_hi && ext_lane_lo));

    // R5: address step between external cycles
    a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && ext_ack && !final_step) |=>
        (ext_addr == $past(ext_addr) + ($past(state_q.is8) ? ADDR_W'(1) : ADDR_W'(2))));

    // R9: the external cycle holds while unacknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && !ext_ack) |=> (busy && $stable(ext_addr) && $stable(ext_wdata)
                                        && $stable(ext_lane_hi) && $stable(ext_lane_lo)));

    // R10: done is a single pulse, and nothing is on the bus while idle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cyc |-> (!ext_lane_hi && !ext_lane_lo && ext_wdata == '0));

    // R8: the last acknowledge releases busy and raises done
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && ext_ack && final_step) |=> (!busy && done));

endmodule

// File: tb/xbus_align_seq_tb.sv
`timescale 1ns/100ps
module xbus_align_seq_tb_top;

    localparam int AW = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid, req_write, area_8bit, ext_ack;
    logic [1:0]     req_size;
    logic [AW-1:0]  req_addr;
    logic [31:0]    req_wdata;
    logic [15:0]    ext_rdata;
    logic           busy, done, ext_cyc, ext_we, ext_lane_hi, ext_lane_lo;
    logic [31:0]    rd_data;
    logic [AW-1:0]  ext_addr;
    logic [15:0]    ext_wdata;

    always #2.5 clk = ~clk;

    xbus_align_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .area_8bit(area_8bit), .busy(busy), .done(done), .rd_data(rd_data),
        .ext_cyc(ext_cyc), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_lane_hi(ext_lane_hi), .ext_lane_lo(ext_lane_lo),
        .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // behavioural model state
    logic [AW-1:0] q_addr[$];
    logic [1:0]    q_lane[$];
    logic [15:0]   q_wd[$];
    bit            m_busy, m_done, m_wr, m_is8;
    int            m_size, m_exp_cyc, obs_cyc;
    logic          m_odd;
    logic [31:0]   m_acc;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_accept(input bit wr, input bit is8, input logic [1:0] sz,
                                input logic [AW-1:0] a, input logic [31:0] wd);
        int nbytes;
        logic [AW-1:0] base;
        nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        q_addr.delete(); q_lane.delete(); q_wd.delete();
        if (is8) begin
            for (int k = 0; k < nbytes; k++) begin
                q_addr.push_back(a + AW'(k));
                q_lane.push_back(2'b10);
                q_wd.push_back({wd[8*(nbytes-1-k) +: 8], 8'h00});
            end
        end else if (nbytes == 1) begin
            q_addr.push_back(a);
            q_lane.push_back(a[0] ? 2'b01 : 2'b10);
            q_wd.push_back(a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00});
        end else begin
            base = {a[AW-1:1], 1'b0};
            for (int k = 0; k < nbytes / 2; k++) begin
                q_addr.push_back(base + AW'(2 * k));
                q_lane.push_back(2'b11);
                q_wd.push_back(wd[16*(nbytes/2-1-k) +: 16]);
            end
        end
        m_busy = 1; m_wr = wr; m_is8 = is8; m_size = nbytes; m_odd = a[0];
        m_acc = 0; m_exp_cyc = q_addr.size();
    endtask

    task automatic model_ack(input logic [15:0] rd);
        if (!m_wr) begin
            if (m_is8) m_acc = {m_acc[23:0], rd[15:8]};
            else if (m_size == 1) m_acc = {m_acc[23:0], m_odd ? rd[7:0] : rd[15:8]};
            else m_acc = {m_acc[15:0], rd};
        end
        void'(q_addr.pop_front()); void'(q_lane.pop_front()); void'(q_wd.pop_front());
        if (q_addr.size() == 0) begin
            m_busy = 0; m_done = 1;
        end
    endtask

    task automatic compare_cycle();
        chk(busy === m_busy, "R8 busy", 32'(busy), 32'(m_busy));
        chk(done === m_done, "R10 done", 32'(done), 32'(m_done));
        chk(ext_cyc === m_busy, "R9 ext_cyc", 32'(ext_cyc), 32'(m_busy));
        if (m_busy) begin
            chk(ext_addr === q_addr[0], "R5 ext_addr", 32'(ext_addr), 32'(q_addr[0]));
            chk({ext_lane_hi, ext_lane_lo} === q_lane[0], m_is8 ? "R2 lanes" : "R6 lanes",
                32'({ext_lane_hi, ext_lane_lo}), 32'(q_lane[0]));
            chk(ext_we === m_wr, "R9 ext_we", 32'(ext_we), 32'(m_wr));
            chk(ext_wdata === (m_wr ? q_wd[0] : 16'h0), "R4 ext_wdata",
                32'(ext_wdata), 32'(m_wr ? q_wd[0] : 16'h0));
        end else begin
            chk({ext_lane_hi, ext_lane_lo} === 2'b00, "R10 idle lanes",
                32'({ext_lane_hi, ext_lane_lo}), 32'h0);
        end
        if (m_done && !m_wr)
            chk(rd_data === m_acc, "R7 rd_data", rd_data, m_acc);
        if (done) begin
            chk(obs_cyc == m_exp_cyc, "R3 cycle count", 32'(obs_cyc), 32'(m_exp_cyc));
            obs_cyc = 0;
        end
    endtask

    initial begin
        int dir_idx;
        bit do_ack;
        rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0;
        req_wdata = 0; area_8bit = 0; ext_ack = 0; ext_rdata = 0;
        m_busy = 0; m_done = 0; m_wr = 0; m_is8 = 0; m_size = 1; m_odd = 0;
        m_acc = 0; m_exp_cyc = 0; obs_cyc = 0; dir_idx = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ext_cyc && !ext_lane_hi && !ext_lane_lo, "R1 reset outputs",
            32'({busy, done, ext_cyc, ext_lane_hi, ext_lane_lo}), 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !ext_cyc, "R1 after reset", 32'({busy, done, ext_cyc}), 32'h0);
        for (int cyc = 0; cyc < 6000; cyc++) begin
            @(negedge clk);
            compare_cycle();
            m_done = 0;
            ext_rdata = 16'($urandom);
            do_ack = 0;
            if (!m_busy) begin
                if (dir_idx < 24) begin
                    req_valid = 1;
                    area_8bit = dir_idx[0];
                    req_write = dir_idx[1];
                    req_size  = 2'((dir_idx / 4) % 3);
                    req_addr  = 16'h1230 + AW'((dir_idx / 12) % 2);
                    req_wdata = 32'hA1B2C3D4 ^ 32'(dir_idx);
                    dir_idx++;
                end else begin
                    req_valid = ($urandom % 4) != 0;
                    area_8bit = 1'($urandom);
                    req_write = 1'($urandom);
                    req_size  = 2'($urandom);
                    req_addr  = (($urandom % 8) == 0) ? AW'(16'hFFFD + ($urandom % 3)) : AW'($urandom);
                    req_wdata = $urandom;
                end
                ext_ack = 0;
                if (req_valid)
                    model_accept(req_write, area_8bit, req_size, req_addr, req_wdata);
            end else begin
                // requests offered during busy must be ignored (R8)
                req_valid = 1'($urandom);
                req_write = 1'($urandom);
                req_size  = 2'($urandom);
                req_addr  = AW'($urandom);
                req_wdata = $urandom;
                area_8bit = 1'($urandom);
                do_ack = ($urandom % 3) == 0;
                ext_ack = do_ack;
                if (ext_cyc && do_ack) obs_cyc++;
                if (do_ack) model_ack(ext_rdata);
            end
        end
        @(negedge clk);
        req_valid = 0; ext_ack = 0;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule